// File: doc/BRIEF.md
# Two-Overflow Watchdog Timer

This block is a watchdog timer with a small register interface on a peripheral clock. Its counter runs from a separate oscillator clock. Software programs a 12-bit period, turns the counter on, and then keeps the watchdog alive by writing a clear command. When one full period passes with no clear, the watchdog raises an interrupt and sets a sticky flag. If a second full period passes while that flag is still set, the watchdog asserts a reset output. The reset output stays high until the module reset is applied. A separate forced-error path can also drive the reset, or the interrupt, whenever software asks for it.

Every register write crosses into the oscillator domain through a toggle synchronizer that carries one write at a time. A write is only accepted on the bus side while no earlier write is still crossing; a write that arrives during that time is dropped. The clear command has its own crossing and is never blocked. When the two clocks are the same, a write sampled on bus edge k takes effect on oscillator edge k+3. The bus side can accept the next crossing write from edge k+6 onward.

Top module: `wdt_dual_overflow`

## Requirements
- R1: After reset, wdt_irq and wdt_rst are 0. Reads return 0 at offsets 0x00, 0x04 and 0x0C. The forced-error routing register at 0x10 reads 1 (forced errors go to the interrupt).
- R2: The registers are at byte offsets 0x00 (control, bit 0 = count enable), 0x04 (period), 0x08 (count restart), 0x0C (clear and flag), 0x10 (error routing) and 0x14 (error force). With both clocks equal, a write sampled on edge k takes effect on oscillator edge k+3.
- R3: The period N sits in bits [31:20] of offset 0x04. The other bits of a write are discarded, and a read returns N in bits [31:20] with zeros below.
- R4: While enabled, the counter wraps every 2^PRE_LOG2 × (N+1) oscillator cycles. The first wrap after a clear sets the flag and wdt_irq. The flag reads back in bit 0 of 0x0C.
- R5: A wrap that happens while the flag is already set asserts wdt_rst. wdt_rst then stays at 1, whatever is written, until rst_n is asserted.
- R6: A write to 0x0C with bit 0 = 1 zeroes the count and the flag. A write to 0x0C with bit 0 = 0 has no effect.
- R7: Any write to 0x08 restarts the count from zero, which delays the next wrap.
- R8: A write to 0x04 is ignored while the control enable bit is 1. The read-back value and the wrap timing both keep the old period.
- R9: A write to 0x14 with bit 0 = 1 forces an error. If 0x10 holds 0, the forced error asserts wdt_rst. If 0x10 holds 1, it sets only the flag and wdt_irq.
- R10: Any write other than a clear that arrives within 5 bus edges after an accepted write is dropped.
- R11: While the enable bit is 0, the count holds its value. Counting resumes from that value when the counter is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Register interface clock |
| oclk | input | 1 | Oscillator clock for the counter |
| rst_n | input | 1 | Asynchronous active-low module reset for both domains |
| wr_en | input | 1 | Write strobe, sampled on pclk |
| addr | input | AW | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr; combinational |
| wdt_irq | output | 1 | First-overflow interrupt (oclk domain) |
| wdt_rst | output | 1 | Sticky reset request (oclk domain) |

## Verification
A wrong count, period or enable state inside the block shows up at the ports as a wrap that comes too early or too late. That error appears on wdt_irq within one period and on wdt_rst within two periods. The bench's per-cycle model therefore catches it on the exact oscillator edge where the two disagree. A wrongly dropped or wrongly accepted crossing write shows up a few bus cycles later, in the read-back value at 0x00, 0x04 or 0x10. Because the clock-domain crossing shifts every effect by three edges, any error in its latency appears as a one-edge mismatch on the outputs.

// File: rtl/wdt_dual_overflow.sv
module wdt_dual_overflow #(
  parameter int PRE_LOG2 = 20,
  parameter int PER_W    = 12,
  parameter int AW       = 5
) (
  input  logic          pclk,
  input  logic          oclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          wdt_irq,
  output logic          wdt_rst
);
  localparam int CW = PRE_LOG2 + PER_W;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_SET  = AW'(4);
  localparam logic [AW-1:0] A_CNT  = AW'(8);
  localparam logic [AW-1:0] A_CLR  = AW'(12);
  localparam logic [AW-1:0] A_PECR = AW'(16);
  localparam logic [AW-1:0] A_PEEN = AW'(20);

  typedef enum logic [2:0] {K_CTRL, K_SET, K_CNT, K_PECR, K_PEEN} kind_e;

  // ---------------- bus side ----------------
  logic req_t, ack_a, ack_b, ref_t, irq_a, irq_b;
  logic en_sh, route_sh;
  logic [PER_W-1:0] per_sh;
  kind_e h_kind;
  logic [31:0] h_data;
  kind_e w_kind;
  logic w_ok;
  logic ack_t, irq_q;

  wire pending = req_t ^ ack_b;
  wire take    = wr_en && w_ok && !pending;
  wire kick    = wr_en && (addr == A_CLR) && wdata[0];

  always_comb begin
    w_kind = K_CTRL;
    w_ok   = 1'b1;
    case (addr)
      A_CTRL:  w_kind = K_CTRL;
      A_SET:   begin w_kind = K_SET;  w_ok = !en_sh;   end
      A_CNT:   w_kind = K_CNT;
      A_PECR:  w_kind = K_PECR;
      A_PEEN:  begin w_kind = K_PEEN; w_ok = wdata[0]; end
      default: w_ok = 1'b0;
    endcase
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      req_t <= 1'b0; ref_t <= 1'b0; ack_a <= 1'b0; ack_b <= 1'b0;
      irq_a <= 1'b0; irq_b <= 1'b0;
      en_sh <= 1'b0; route_sh <= 1'b1; per_sh <= '0;
      h_kind <= K_CTRL; h_data <= '0;
    end else begin
      ack_a <= ack_t;
      ack_b <= ack_a;
      irq_a <= irq_q;
      irq_b <= irq_a;
      if (kick) ref_t <= ~ref_t;
      if (take) begin
        req_t  <= ~req_t;
        h_kind <= w_kind;
        h_data <= wdata;
        if (w_kind == K_CTRL) en_sh    <= wdata[0];
        if (w_kind == K_SET)  per_sh   <= wdata[31 -: PER_W];
        if (w_kind == K_PECR) route_sh <= wdata[0];
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {31'd0, en_sh};
      A_SET:   rdata = {per_sh, {(32-PER_W){1'b0}}};
      A_CLR:   rdata = {31'd0, irq_b};
      A_PECR:  rdata = {31'd0, route_sh};
      default: rdata = 32'd0;
    endcase
  end

  // ---------------- oscillator side ----------------
  logic rq1, rq2, rq3, rf1, rf2, rf3;
  logic en, route, rst_q;
  logic [PER_W-1:0] per;
  logic [CW-1:0] cnt;

  wire apply    = rq2 ^ rq3;
  wire refresh  = rf2 ^ rf3;
  wire zero_cnt = apply && (h_kind == K_CNT);
  wire force_pe = apply && (h_kind == K_PEEN);
  wire [CW-1:0] lim = {per, {PRE_LOG2{1'b1}}};
  wire hit = en && (cnt == lim) && !refresh && !zero_cnt;

  always_ff @(posedge oclk or negedge rst_n) begin
    if (!rst_n) begin
      rq1 <= 1'b0; rq2 <= 1'b0; rq3 <= 1'b0;
      rf1 <= 1'b0; rf2 <= 1'b0; rf3 <= 1'b0;
      ack_t <= 1'b0; en <= 1'b0; route <= 1'b1; per <= '0;
      cnt <= '0; irq_q <= 1'b0; rst_q <= 1'b0;
    end else begin
      rq1 <= req_t; rq2 <= rq1; rq3 <= rq2;
      rf1 <= ref_t; rf2 <= rf1; rf3 <= rf2;
      ack_t <= rq2;
      if (refresh || zero_cnt) cnt <= '0;
      else if (hit)            cnt <= '0;
      else if (en)             cnt <= cnt + 1'b1;
      if (refresh)                          irq_q <= 1'b0;
      else if (hit || (force_pe && route))  irq_q <= 1'b1;
      if ((hit && irq_q) || (force_pe && !route)) rst_q <= 1'b1;
      if (apply) begin
        case (h_kind)
          K_CTRL:  en    <= h_data[0];
          K_SET:   per   <= h_data[31 -: PER_W];
          K_PECR:  route <= h_data[0];
          default: ;
        endcase
      end
    end
  end

  assign wdt_irq = irq_q;
  assign wdt_rst = rst_q;

  // R5: reset request is sticky
  a_r5_rst_sticky: assert property (@(posedge oclk) disable iff (!rst_n)
    wdt_rst |=> wdt_rst);
  // R5 R9: reset rises only from a second wrap or a routed forced error
  a_r5_rst_cause: assert property (@(posedge oclk) disable iff (!rst_n)
    $rose(rst_q) |-> ($past(irq_q) || $past(force_pe)));
  // R4 R9: flag rises only from a wrap or a forced error
  a_r4_irq_cause: assert property (@(posedge oclk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(en && cnt == lim) || $past(force_pe)));
  // R6: refresh zeroes count and flag
  a_r6_refresh_clears: assert property (@(posedge oclk) disable iff (!rst_n)
    refresh |=> (cnt == '0 && !irq_q));
  // R11: disabled counter holds
  a_r11_hold: assert property (@(posedge oclk) disable iff (!rst_n)
    (!en && !refresh && !zero_cnt) |=> $stable(cnt));
  // R10: a pending crossing keeps its payload
  a_r10_payload_stable: assert property (@(posedge pclk) disable iff (!rst_n)
    pending |=> $stable(h_data));
  // R8: period shadow frozen while enabled
  a_r8_period_locked: assert property (@(posedge pclk) disable iff (!rst_n)
    en_sh |=> $stable(per_sh));
endmodule

// File: tb/sim_wdt_dual_overflow.sv
`timescale 1ns/1ps
module sim_wdt_dual_overflow;
  localparam int PRE = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic wdt_irq, wdt_rst;

  always #2.5 clk = ~clk;

  wdt_dual_overflow #(.PRE_LOG2(PRE), .PER_W(12), .AW(5)) u0 (
    .pclk(clk), .oclk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wdt_irq(wdt_irq), .wdt_rst(wdt_rst));

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  int q_t[$], q_a[$];
  logic [31:0] q_d[$];
  int last_acc = -100;
  bit s_en = 0;
  int m_cnt = 0, m_per = 0;
  bit m_en = 0, m_irq = 0, m_rst = 0, m_route = 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (!rst_n) begin
      q_t.delete(); q_a.delete(); q_d.delete();
      m_cnt = 0; m_per = 0; m_en = 0; m_irq = 0; m_rst = 0; m_route = 1;
    end else begin
      bit ev_ref, ev_zero, ev_force, ev_cfg;
      int a;
      logic [31:0] d;
      ev_ref = 0; ev_zero = 0; ev_force = 0; ev_cfg = 0; a = 0; d = '0;
      while (q_t.size() > 0 && q_t[0] == cyc) begin
        a = q_a[0]; d = q_d[0];
        void'(q_t.pop_front()); void'(q_a.pop_front()); void'(q_d.pop_front());
        if (a == 12) ev_ref = 1;
        else if (a == 8) ev_zero = 1;
        else if (a == 20) ev_force = 1;
        else ev_cfg = 1;
      end
      if (ev_ref) begin m_cnt = 0; m_irq = 0; end
      else if (ev_zero) m_cnt = 0;
      else if (m_en) begin
        if (m_cnt == ((m_per + 1) << PRE) - 1) begin
          m_cnt = 0;
          if (m_irq) m_rst = 1; else m_irq = 1;
        end else m_cnt++;
      end
      if (ev_force) begin
        if (!m_route) m_rst = 1; else m_irq = 1;
      end
      if (ev_cfg) begin
        if (a == 0) m_en = d[0];
        else if (a == 4) m_per = int'(d[31:20]);
        else if (a == 16) m_route = d[0];
      end
    end
    chk("R4 R5 per-cycle irq", {31'd0, wdt_irq}, {31'd0, m_irq});
    chk("R4 R5 per-cycle rst", {31'd0, wdt_rst}, {31'd0, m_rst});
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    int k;
    bit ok;
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(a); wdata = d;
    k = cyc + 1;
    if (a == 12) begin
      if (d[0]) begin q_t.push_back(k + 3); q_a.push_back(a); q_d.push_back(d); end
    end else begin
      ok = (a == 0) || (a == 8) || (a == 16) || (a == 4 && !s_en) || (a == 20 && d[0]);
      if (ok && k > last_acc + 5) begin
        last_acc = k;
        q_t.push_back(k + 3); q_a.push_back(a); q_d.push_back(d);
        if (a == 0) s_en = d[0];
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = 5'(a);
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    last_acc = -100; s_en = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 irq", {31'd0, wdt_irq}, 32'd0);
    chk("R1 rst", {31'd0, wdt_rst}, 32'd0);
    rd(0, 32'd0, "R1 ctrl");
    rd(4, 32'd0, "R1 period");
    rd(12, 32'd0, "R1 flag");
    rd(16, 32'd1, "R1 routing");
    // R3 period field, N=2 -> 48-cycle wrap
    wr(4, 32'h002A_BCDE);
    idle(6);
    rd(4, 32'h0020_0000, "R3 period readback");
    // R2 R4 enable and first wrap
    wr(0, 32'd1);
    idle(60);
    chk("R4 irq after first wrap", {31'd0, wdt_irq}, 32'd1);
    rd(12, 32'd1, "R4 flag readback");
    chk("R2 R5 no reset yet", {31'd0, wdt_rst}, 32'd0);
    // R6 clear with bit0=0 is ignored
    wr(12, 32'd0);
    idle(10);
    chk("R6 zero-bit clear ignored", {31'd0, wdt_irq}, 32'd1);
    wr(12, 32'd1);
    idle(10);
    chk("R6 clear drops irq", {31'd0, wdt_irq}, 32'd0);
    idle(110);
    chk("R5 reset after two wraps", {31'd0, wdt_rst}, 32'd1);
    wr(12, 32'd1);
    idle(10);
    chk("R5 reset sticky after clear", {31'd0, wdt_rst}, 32'd1);
    do_reset();
    chk("R1 R5 reset cleared by rst_n", {31'd0, wdt_rst}, 32'd0);
    // R8 period locked while enabled, N=0 -> 16-cycle wrap
    wr(0, 32'd1);
    wr(4, 32'h0050_0000);
    rd(4, 32'd0, "R8 period unchanged");
    idle(8);
    // R7 count restart
    wr(8, 32'd0);
    idle(12);
    chk("R7 restart delays wrap", {31'd0, wdt_irq}, 32'd0);
    idle(10);
    chk("R7 wrap after restart", {31'd0, wdt_irq}, 32'd1);
    // R11 disable holds count
    wr(12, 32'd1);
    idle(8);
    wr(0, 32'd0);
    idle(40);
    chk("R11 disabled no wrap", {31'd0, wdt_irq}, 32'd0);
    wr(0, 32'd1);
    idle(20);
    chk("R11 resumes and wraps", {31'd0, wdt_irq}, 32'd1);
    do_reset();
    // R10 second write inside busy window dropped
    wr(0, 32'd1);
    wr(0, 32'd0);
    idle(8);
    rd(0, 32'd1, "R10 dropped write");
    idle(30);
    chk("R10 counter still enabled", {31'd0, wdt_irq}, 32'd1);
    do_reset();
    // R9 forced error routing
    wr(20, 32'd1);
    idle(6);
    chk("R9 force to irq", {31'd0, wdt_irq}, 32'd1);
    chk("R9 force no rst", {31'd0, wdt_rst}, 32'd0);
    wr(16, 32'd0);
    idle(8);
    rd(16, 32'd0, "R9 routing readback");
    wr(20, 32'd1);
    idle(6);
    chk("R9 force to rst", {31'd0, wdt_rst}, 32'd1);
    idle(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule